// File: doc/BRIEF.md
# Dual-Frame Codec Serial Port Controller

This block is the master-side serial port of a voice-band codec. Each cycle of `clk` is one shift-clock period. On request it opens a 16-bit primary frame: it raises the frame-sync output and shifts out the converter sample, MSB first. In the same frame it shifts in the playback sample and its two function bits. If both function bits are set, the block waits a programmable number of filter-clock ticks, equal to half the B value rounded down. It then opens a secondary frame that carries a register command word inward. Outward it carries either zeros or a read-back byte.

In slave mode an external frame-sync input starts both kinds of frame, and the block never drives its own frame-sync output. A command word received in one secondary frame can ask for a register read. The byte on `rd_data` is then returned in the low half of the next secondary frame.

The controller is one state machine with four states. IDLE waits for a frame start. PRIM runs the primary frame. WAIT times the gap before a secondary frame. SEC runs the secondary frame. The transitions are:
- start (IDLE→PRIM): on `prim_start`, or on a rising `fs_in` in slave mode.
- end_plain (PRIM→IDLE): after bit 16 when the function bits are not 11.
- end_request (PRIM→WAIT): after bit 16 when the function bits are 11.
- gap_done (WAIT→SEC): on delay expiry, or on a rising `fs_in` in slave mode.
- end_sec (SEC→IDLE): after bit 16.

Top module: `codec_serial_port`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `fs_out`, `dout`, `dac_valid` and `cmd_valid` are 0.
- R2: In master mode, `prim_start` sampled high in IDLE makes `fs_out` high for exactly 16 cycles, starting in the next cycle.
- R3: In the primary frame, `dout` sends `adc_sample[13:0]` MSB first, then two tag bits: 00 in master mode, 01 in slave mode. Outside frames `dout` is 0.
- R4: `din` is taken MSB first, one bit per frame cycle. After a primary frame, `dac_word` holds received bits 15:2 and `dac_func` holds bits 1:0, with `dac_valid` high for exactly one cycle.
- R5: A secondary frame follows only when `dac_func` is 11. Otherwise the block returns to IDLE.
- R6: In master mode, a secondary frame starts after the primary frame ends and floor(`b_value`/2) `filt_tick` pulses have been counted in WAIT. It starts on the clock edge after the count is reached, so B = 0 or 1 gives a one-cycle gap. Its `fs_out` is high for 16 cycles.
- R7: Secondary `dout` is all zeros unless the previous command was a read. In that case bits 7:0 carry `rd_data`, sampled at the edge that opens the frame.
- R8: After a secondary frame, `cmd_valid` pulses for one cycle. `cmd_read` = bit 13, `cmd_addr` = bits 12:8 and `cmd_data` = bits 7:0 of the received word. Bits 15:14 are ignored. `dac_valid` and `cmd_valid` are never high together.
- R9: `prim_start` has no effect outside IDLE, including the cycle in which the delay expires.
- R10: In slave mode, `fs_out` stays 0. A primary frame starts on a rising `fs_in` in IDLE, and a pending secondary frame starts on the next rising `fs_in`. `filt_tick` is then irrelevant.
- R11: `filt_tick` pulses outside WAIT, including those during the primary frame, do not shorten the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; one bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| slave_mode | input | 1 | 1 = frame sync supplied on `fs_in` |
| prim_start | input | 1 | Master-mode request for a primary frame |
| fs_in | input | 1 | External frame sync (slave mode) |
| filt_tick | input | 1 | One-cycle filter-clock tick |
| b_value | input | 8 | Delay setting; gap is b_value/2 ticks |
| adc_sample | input | 14 | Two's-complement converter sample |
| rd_data | input | 8 | Register read-back byte |
| din | input | 1 | Serial data in |
| fs_out | output | 1 | Generated frame sync |
| dout | output | 1 | Serial data out |
| dac_valid | output | 1 | Primary word received (pulse) |
| dac_word | output | 14 | Received playback sample |
| dac_func | output | 2 | Received function bits |
| cmd_valid | output | 1 | Command word received (pulse) |
| cmd_read | output | 1 | Command asks for a read |
| cmd_addr | output | 5 | Command register address |
| cmd_data | output | 8 | Command write data |

## Verification
Two events can fall in the same cycle: expiry of the secondary-frame delay, and a new primary request. The bench provokes this by holding `prim_start` high across a whole primary, gap and secondary sequence, with a filter tick on every cycle. It also sends ticks during the primary frame to confirm that they are not counted. A behavioural model decides every cycle whether the secondary frame opens and whether the request is ignored. It then compares `fs_out`, `dout` and the received words with the design on every clock.

// File: rtl/codec_sp_pkg.sv
package codec_sp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRIM = 2'd1,
        ST_WAIT = 2'd2,
        ST_SEC  = 2'd3
    } sp_state_e;
endpackage

// File: rtl/sp_bit_counter.sv
module sp_bit_counter #(
    parameter int WORD_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] cnt_q;

    assign last = run && (cnt_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst || !run || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sp_tx_shifter.sv
module sp_tx_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    output logic              msb
);
    logic [WORD_W-1:0] sr_q;

    assign msb = sr_q[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_word;
        end else if (shift) begin
            sr_q <= {sr_q[WORD_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/sp_rx_shifter.sv
module sp_rx_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift,
    input  logic              din,
    output logic [WORD_W-1:0] full_word
);
    logic [WORD_W-1:0] sr_q;

    // word including the bit arriving in this cycle
    assign full_word = {sr_q[WORD_W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (shift) begin
            sr_q <= full_word;
        end
    end
endmodule

// File: rtl/sp_delay_timer.sv
module sp_delay_timer #(
    parameter int B_W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           active,
    input  logic           tick,
    input  logic [B_W-1:0] b_value,
    output logic           expired
);
    localparam logic [B_W-1:0] CNT_MAX = '1;

    logic [B_W-1:0] cnt_q;
    logic [B_W-1:0] half_b;

    assign half_b  = b_value >> 1;
    assign expired = active && (cnt_q >= half_b);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/codec_serial_port.sv
module codec_serial_port
    import codec_sp_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SAMP_W = 14,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int B_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slave_mode,
    input  logic              prim_start,
    input  logic              fs_in,
    input  logic              filt_tick,
    input  logic [B_W-1:0]    b_value,
    input  logic [SAMP_W-1:0] adc_sample,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              din,
    output logic              fs_out,
    output logic              dout,
    output logic              dac_valid,
    output logic [SAMP_W-1:0] dac_word,
    output logic [WORD_W-SAMP_W-1:0] dac_func,
    output logic              cmd_valid,
    output logic              cmd_read,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);
    localparam int FUNC_W = WORD_W - SAMP_W;
    localparam int RD_BIT = ADDR_W + DATA_W;
    localparam logic [FUNC_W-1:0] FUNC_REQ = '1;

    sp_state_e state_q, state_d;

    logic fs_in_q, fs_rise, start_prim, sec_go;
    logic in_frame, last_bit, delay_done, read_pend_q;
    logic tx_load, tx_msb;
    logic [WORD_W-1:0] tx_word, rx_full;
    logic [WORD_W-1:0] prim_word, sec_word;

    // frame-start events
    assign fs_rise    = fs_in && !fs_in_q;
    assign start_prim = slave_mode ? fs_rise : prim_start;
    assign sec_go     = slave_mode ? fs_rise : delay_done;
    assign in_frame   = (state_q == ST_PRIM) || (state_q == ST_SEC);

    // words loaded into the transmit shifter
    assign prim_word = {adc_sample, {(FUNC_W-1){1'b0}}, slave_mode};
    assign sec_word  = read_pend_q ? {{(WORD_W-DATA_W){1'b0}}, rd_data} : '0;
    assign tx_load   = ((state_q == ST_IDLE) && start_prim) ||
                       ((state_q == ST_WAIT) && sec_go);
    assign tx_word   = (state_q == ST_WAIT) ? sec_word : prim_word;

    sp_bit_counter #(.WORD_W(WORD_W)) u_bitcnt (
        .clk  (clk),
        .rst  (rst),
        .run  (in_frame),
        .last (last_bit)
    );

    sp_tx_shifter #(.WORD_W(WORD_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (tx_load),
        .load_word (tx_word),
        .shift     (in_frame),
        .msb       (tx_msb)
    );

    sp_rx_shifter #(.WORD_W(WORD_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .shift     (in_frame),
        .din       (din),
        .full_word (rx_full)
    );

    sp_delay_timer #(.B_W(B_W)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .active  (state_q == ST_WAIT),
        .tick    (filt_tick),
        .b_value (b_value),
        .expired (delay_done)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_prim) state_d = ST_PRIM;
            ST_PRIM: if (last_bit) begin
                state_d = (rx_full[FUNC_W-1:0] == FUNC_REQ) ? ST_WAIT : ST_IDLE;
            end
            ST_WAIT: if (sec_go) state_d = ST_SEC;
            ST_SEC:  if (last_bit) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // serial outputs
    always_comb begin
        fs_out = in_frame && !slave_mode;
        dout   = in_frame && tx_msb;
    end

    // sync capture and received-word outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            fs_in_q     <= 1'b0;
            read_pend_q <= 1'b0;
            dac_valid   <= 1'b0;
            cmd_valid   <= 1'b0;
            dac_word    <= '0;
            dac_func    <= '0;
            cmd_read    <= 1'b0;
            cmd_addr    <= '0;
            cmd_data    <= '0;
        end else begin
            fs_in_q   <= fs_in;
            dac_valid <= (state_q == ST_PRIM) && last_bit;
            cmd_valid <= (state_q == ST_SEC) && last_bit;
            if ((state_q == ST_PRIM) && last_bit) begin
                dac_word <= rx_full[WORD_W-1:FUNC_W];
                dac_func <= rx_full[FUNC_W-1:0];
            end
            if ((state_q == ST_SEC) && last_bit) begin
                cmd_read    <= rx_full[RD_BIT];
                cmd_addr    <= rx_full[RD_BIT-1:DATA_W];
                cmd_data    <= rx_full[DATA_W-1:0];
                read_pend_q <= rx_full[RD_BIT];
            end
        end
    end
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
    parameter int WORD_W = 16
) (
    input logic clk,
    input logic rst,
    input logic slave_mode,
    input logic fs_out,
    input logic dout,
    input logic dac_valid,
    input logic cmd_valid
);
    localparam int RUN_W = $clog2(WORD_W) + 2;

    logic             rst_q;
    logic [RUN_W-1:0] fs_run;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            fs_run <= '0;
        end else begin
            fs_run <= fs_out ? fs_run + 1'b1 : '0;
        end
    end

    // R1: quiet outputs the cycle after reset
    always @(posedge clk) begin
        if (rst_q) begin
            assert_reset_quiet_R1: assert (!fs_out && !dout && !dac_valid && !cmd_valid)
                else $error("outputs active after reset");
        end
    end

    assert_fs_max_R2: assert property (@(posedge clk) disable iff (rst)
        fs_out |-> (fs_run < RUN_W'(WORD_W)));

    assert_fs_width_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(fs_out) |-> (fs_run == RUN_W'(WORD_W)));

    assert_dout_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (!slave_mode && !fs_out) |-> !dout);

    assert_dac_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        dac_valid |=> !dac_valid);

    assert_cmd_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    assert_valid_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(dac_valid && cmd_valid));

    assert_slave_no_fs_R10: assert property (@(posedge clk) disable iff (rst)
        slave_mode |-> !fs_out);
endmodule

bind codec_serial_port sp_checker #(.WORD_W(WORD_W)) u_sp_checker (
    .clk        (clk),
    .rst        (rst),
    .slave_mode (slave_mode),
    .fs_out     (fs_out),
    .dout       (dout),
    .dac_valid  (dac_valid),
    .cmd_valid  (cmd_valid)
);

// File: tb/codec_serial_port_tb_top.sv
module codec_serial_port_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slave_mode = 1'b0;
    logic        prim_start = 1'b0;
    logic        fs_in = 1'b0;
    logic        filt_tick = 1'b0;
    logic [7:0]  b_value = 8'd0;
    logic [13:0] adc_sample = 14'd0;
    logic [7:0]  rd_data = 8'd0;
    logic        din = 1'b0;
    logic        fs_out, dout, dac_valid, cmd_valid, cmd_read;
    logic [13:0] dac_word;
    logic [1:0]  dac_func;
    logic [4:0]  cmd_addr;
    logic [7:0]  cmd_data;

    always #10 clk = ~clk;

    codec_serial_port dut_i (
        .clk(clk), .rst(rst), .slave_mode(slave_mode), .prim_start(prim_start),
        .fs_in(fs_in), .filt_tick(filt_tick), .b_value(b_value),
        .adc_sample(adc_sample), .rd_data(rd_data), .din(din),
        .fs_out(fs_out), .dout(dout), .dac_valid(dac_valid), .dac_word(dac_word),
        .dac_func(dac_func), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    // behavioural reference model: 0 idle, 1 primary, 2 gap, 3 secondary
    int          ms = 0;
    int          nbit = 0;
    int          ticks = 0;
    bit          fs_prev = 0;
    bit          rd_pend = 0;
    bit          txq[$];
    logic [15:0] rxw = '0;
    bit          m_dv = 0, m_cv = 0;
    logic [13:0] e_dac = '0;
    logic [1:0]  e_fn = '0;
    bit          e_rd = 0;
    logic [4:0]  e_ad = '0;
    logic [7:0]  e_dt = '0;

    logic [15:0] pw = '0, sw = '0;
    int          tick_per = 0, tcnt = 0;
    bit          noise = 0;
    int          vectors = 0, fails = 0, cyc = 0;
    bit          done = 0;

    task automatic push_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) txq.push_back(w[i]);
    endtask

    always @(posedge clk) begin
        bit rise;
        if (rst) begin
            ms = 0; nbit = 0; ticks = 0; fs_prev = 0; rd_pend = 0;
            txq.delete(); m_dv = 0; m_cv = 0; rxw = '0;
        end else begin
            rise = fs_in && !fs_prev;
            fs_prev = fs_in;
            m_dv = 0; m_cv = 0;
            case (ms)
                0: if (slave_mode ? rise : prim_start) begin
                    txq.delete();
                    push_word({adc_sample, 1'b0, slave_mode});
                    nbit = 0; ms = 1;
                end
                1, 3: begin
                    rxw = {rxw[14:0], din};
                    void'(txq.pop_front());
                    nbit++;
                    if (nbit == 16) begin
                        if (ms == 1) begin
                            m_dv = 1; e_dac = rxw[15:2]; e_fn = rxw[1:0];
                            ms = (rxw[1:0] == 2'b11) ? 2 : 0;
                            ticks = 0;
                        end else begin
                            m_cv = 1; e_rd = rxw[13]; e_ad = rxw[12:8]; e_dt = rxw[7:0];
                            rd_pend = rxw[13];
                            ms = 0;
                        end
                    end
                end
                2: begin
                    if (slave_mode ? rise : (ticks >= int'(b_value) / 2)) begin
                        txq.delete();
                        push_word(rd_pend ? {8'h00, rd_data} : 16'h0000);
                        nbit = 0; ms = 3;
                    end else if (filt_tick) begin
                        ticks++;
                    end
                end
                default: ms = 0;
            endcase
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", what, act, exp, cyc);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        bit fr;
        if (!done) begin
            fr = (ms == 1 || ms == 3);
            if (rst) begin
                chk("R1 fs_out in reset", 32'(fs_out), 32'(0));
            end else begin
                chk("fs_out R2 R5 R6 R9 R10 R11", 32'(fs_out), 32'(!slave_mode && fr));
                chk("dout R3 R7", 32'(dout), 32'((fr && txq.size() > 0) ? txq[0] : 1'b0));
                chk("dac_valid R1 R4 R5", 32'(dac_valid), 32'(m_dv));
                chk("cmd_valid R1 R5 R8", 32'(cmd_valid), 32'(m_cv));
                if (m_dv) chk("dac_word/func R4", {16'(dac_word), 16'(dac_func)},
                              {16'(e_dac), 16'(e_fn)});
                if (m_cv) chk("cmd fields R8", {16'(cmd_read), 8'(cmd_addr), cmd_data},
                              {16'(e_rd), 8'(e_ad), e_dt});
            end
            // serial input and filter tick stimulus
            if (ms == 1)      din = pw[15 - nbit];
            else if (ms == 3) din = sw[15 - nbit];
            else begin noise = ~noise; din = noise; end
            if (tick_per > 0) begin
                tcnt++;
                filt_tick = (tcnt % tick_per) == 0;
            end else begin
                filt_tick = 1'b0;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            fails++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (ms != 0) @(negedge clk);
    endtask

    task automatic master_frame(input logic [13:0] a, input logic [15:0] p, input logic [15:0] s);
        adc_sample = a; pw = p; sw = s;
        @(negedge clk); prim_start = 1'b1;
        @(negedge clk); prim_start = 1'b0;
        wait_idle();
        idle(4);
    endtask

    task automatic fs_pulse(input int w);
        @(negedge clk); fs_in = 1'b1;
        repeat (w) @(negedge clk);
        fs_in = 1'b0;
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(2);
        // R5: function bits other than 11 give no secondary frame
        b_value = 8'd10; tick_per = 2;
        master_frame(14'h1A5C, 16'hABC0, 16'h0000);
        master_frame(14'h2001, 16'h1235, 16'h0000);
        master_frame(14'h3FFF, 16'hFFFE, 16'h0000);
        // R6: B of 0 and 1 give a one-cycle gap; write command
        b_value = 8'd0;
        master_frame(14'h0001, 16'h8003, 16'h0A5A);
        b_value = 8'd1;
        master_frame(14'h2AAA, 16'h7FFF, 16'h3FC3);      // read request, R8
        // R7: read-back byte returned; ticks during primary not counted (R11)
        b_value = 8'd7; tick_per = 3; rd_data = 8'hC6;
        master_frame(14'h1555, 16'h4447, 16'h1234);
        b_value = 8'd20; tick_per = 1; rd_data = 8'h3B;
        master_frame(14'h0F0F, 16'h0003, 16'hE0FF);      // bits 15:14 ignored
        // R9: prim_start held high across delay expiry
        b_value = 8'd8; tick_per = 1; rd_data = 8'h81;
        adc_sample = 14'h2468; pw = 16'h5557; sw = 16'h2155;
        @(negedge clk); prim_start = 1'b1;
        idle(150);
        prim_start = 1'b0;
        wait_idle(); idle(4);
        // long gap
        b_value = 8'd255; tick_per = 1;
        master_frame(14'h3001, 16'h9993, 16'h0000);
        // R10: slave mode
        @(negedge clk); rst = 1'b1; slave_mode = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(2);
        adc_sample = 14'h0F0F; pw = 16'hC003; sw = 16'h2A11; tick_per = 1;
        fs_pulse(2);
        idle(40);
        fs_pulse(1);
        wait_idle(); idle(4);
        adc_sample = 14'h3C3C; pw = 16'h1230; rd_data = 8'h96;
        fs_pulse(3);
        idle(25);
        fs_pulse(1);                                      // new primary, not secondary
        wait_idle(); idle(4);
        pw = 16'hFFFF; sw = 16'h0000;
        fs_pulse(1);
        idle(30);
        fs_pulse(2);
        wait_idle(); idle(4);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule